// File: doc/BRIEF.md
# Pipelined Bus Snoop-Phase Tracker

This block follows the transactions that are in flight on a split-phase, pipelined system bus and settles the snoop phase of each one. Each accepted request takes a slot in an in-order queue of up to eight entries. Later request, snoop and data phases of different transactions may overlap freely. The tracker serves only the oldest transaction whose snoop is still open. It samples the wired-OR hit and modified-hit lines from the caching agents at the clock the window closes, and it then does one of three things: it stretches the window, it records the line as clean or shared with memory as the responder, or it gives the response to the cache that holds the modified line and tells memory to capture the data.

The transaction at the head of the queue drives the data-direction outputs once its snoop is settled. It leaves the queue when the response-complete input arrives. When the queue is full the full flag blocks further requests. A request offered while the queue is full is dropped and an error pulse is raised.

Top module: `snoop_tracker`

## Requirements
- R1: While reset is applied and in the cycles after it releases, q_full, req_err, snp_valid, snp_stall, rd_xfer, wr_xfer and mem_snarf are all 0 and the queue is empty. The first accepted request gets tag 0.
- R2: A request is accepted at a rising edge where req_valid=1 and q_full=0. If no stall occurs, its snoop lines are sampled at the fourth rising edge after acceptance, and snp_valid is 1 for the one cycle that follows that edge.
- R3: The result is encoded on snp_res. With hit=0 and hitm=0 it is 2'b00 (clean). With hit=1 and hitm=0 it is 2'b01 (shared). With hit=0 and hitm=1 it is 2'b10 (modified), and snp_snarf=1 is shown with it. snp_snarf is 0 for any other result.
- R4: If hit=1 and hitm=1 at a sampling edge, no result is produced. snp_stall is 1 for one cycle and the lines are sampled again two edges later. This can happen any number of times, so each stall adds two clocks.
- R5: Snoops are settled strictly in acceptance order. snp_tag counts up by one per result, modulo 8.
- R6: q_full is 1 while eight transactions are held. A request offered while q_full=1 is dropped and causes a one-cycle req_err pulse in the following cycle.
- R7: A rsp_done at a rising edge retires the head transaction only if the head's snoop is settled. Otherwise rsp_done is ignored.
- R8: While the head transaction is settled, rd_xfer=1 for a read (req_write=0) and wr_xfer=1 for a write (req_write=1). Both are 0 when the queue is empty or the head's snoop is still open, and the two are never 1 together.
- R9: mem_snarf is 1 exactly while the settled head transaction has the modified result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request phase present this cycle |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| hit | input | 1 | Wired-OR shared-hit line from the caching agents |
| hitm | input | 1 | Wired-OR modified-hit line from the caching agents |
| rsp_done | input | 1 | Response for the head transaction is complete |
| q_full | output | 1 | Eight transactions are held; new requests are refused |
| req_err | output | 1 | A request was dropped because the queue was full |
| snp_valid | output | 1 | Snoop result present this cycle |
| snp_tag | output | 3 | Queue slot of the result |
| snp_res | output | 2 | Snoop result: 00 clean, 01 shared, 10 modified |
| snp_snarf | output | 1 | The result hands the data to a modified cache; memory must capture it |
| snp_stall | output | 1 | The snoop window was stretched by two clocks |
| rd_xfer | output | 1 | The head read is ready for its data phase |
| wr_xfer | output | 1 | The head write is ready for its data phase |
| mem_snarf | output | 1 | Memory must capture the data of the head transfer |

## Verification
The checks on the source of a result assume that hit and hitm are steady across each rising edge. The bench therefore changes them only a nanosecond after an edge, so whatever is sampled at an edge is what the result is compared against. The error-pulse property assumes that req_valid is a single-cycle request strobe. The bench raises it for one cycle per request and deliberately offers a ninth request while the queue is full. The stall scenarios hold both lines high until the expected number of stall pulses has been seen, and only then set the final snoop answer.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    SNP_CLEAN  = 2'b00,
    SNP_SHARED = 2'b01,
    SNP_MOD    = 2'b10
  } snp_res_e;

  typedef struct packed {
    logic     valid;
    logic     is_wr;
    logic     resolved;
    snp_res_e res;
  } tq_entry_t;

endpackage

// File: rtl/tq_ptrs.sv
module tq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            resolve,
  output logic [IDXW-1:0] wr_ptr,
  output logic [IDXW-1:0] snp_ptr,
  output logic [IDXW-1:0] rd_ptr,
  output logic            full,
  output logic            empty,
  output logic            pend_any
);

  logic [IDXW-1:0] wr_q, wr_d, snp_q, snp_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d, pend_q, pend_d;

  function automatic logic [IDXW-1:0] bump(input logic [IDXW-1:0] p);
    return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d   = push    ? bump(wr_q)  : wr_q;
    snp_d  = resolve ? bump(snp_q) : snp_q;
    rd_d   = pop     ? bump(rd_q)  : rd_q;
    cnt_d  = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
    pend_d = pend_q;
    if (push && !resolve)      pend_d = pend_q + 1'b1;
    else if (resolve && !push) pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      snp_q  <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      wr_q   <= wr_d;
      snp_q  <= snp_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign wr_ptr   = wr_q;
  assign snp_ptr  = snp_q;
  assign rd_ptr   = rd_q;
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign pend_any = (pend_q != '0);

endmodule

// File: rtl/tq_entries.sv
module tq_entries
  import snp_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SNOOP_DLY = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int AMAX = SNOOP_DLY - 1,
  localparam int AW   = (AMAX > 1) ? $clog2(AMAX + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDXW-1:0] push_idx,
  input  logic            push_wr,
  input  logic            res_we,
  input  logic [IDXW-1:0] res_idx,
  input  snp_res_e        res_val,
  input  logic            pop,
  input  logic [IDXW-1:0] pop_idx,
  output logic            snp_due,
  output logic            head_ready,
  output logic            head_wr,
  output snp_res_e        head_res
);

  tq_entry_t       ent_q [DEPTH];
  logic [AW-1:0]   age_q [DEPTH];
  logic [DEPTH-1:0] due_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    tq_entry_t     ent_d;
    logic [AW-1:0] age_d;
    logic          sel_push, sel_res, sel_pop;

    assign sel_push = push   && (push_idx == IDXW'(i));
    assign sel_res  = res_we && (res_idx  == IDXW'(i));
    assign sel_pop  = pop    && (pop_idx  == IDXW'(i));

    always_comb begin
      ent_d = ent_q[i];
      age_d = age_q[i];
      if (sel_pop) begin
        ent_d.valid    = 1'b0;
        ent_d.resolved = 1'b0;
      end
      if (sel_res) begin
        ent_d.resolved = 1'b1;
        ent_d.res      = res_val;
      end
      if (sel_push) begin
        ent_d.valid    = 1'b1;
        ent_d.is_wr    = push_wr;
        ent_d.resolved = 1'b0;
        ent_d.res      = SNP_CLEAN;
        age_d          = '0;
      end else if (ent_q[i].valid && (age_q[i] != AW'(AMAX))) begin
        age_d = age_q[i] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
        age_q[i] <= '0;
      end else begin
        ent_q[i] <= ent_d;
        age_q[i] <= age_d;
      end
    end

    assign due_vec[i] = ent_q[i].valid && !ent_q[i].resolved &&
                        (age_q[i] == AW'(AMAX));
  end

  assign snp_due    = due_vec[res_idx];
  assign head_ready = ent_q[pop_idx].valid && ent_q[pop_idx].resolved;
  assign head_wr    = ent_q[pop_idx].is_wr;
  assign head_res   = ent_q[pop_idx].res;

endmodule

// File: rtl/snoop_ctl.sv
module snoop_ctl
  import snp_pkg::*;
#(
  parameter int STALL_CLKS = 2,
  localparam int SW = $clog2(STALL_CLKS + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pend_any,
  input  logic     due,
  input  logic     hit,
  input  logic     hitm,
  output logic     resolve,
  output logic     stall,
  output snp_res_e res
);

  logic [SW-1:0] wait_q, wait_d;
  logic          sample;

  assign sample = pend_any && due && (wait_q == '0);

  always_comb begin
    stall   = sample && hit && hitm;
    resolve = sample && !(hit && hitm);
    if (hitm)     res = SNP_MOD;
    else if (hit) res = SNP_SHARED;
    else          res = SNP_CLEAN;
    wait_d = wait_q;
    if (stall)              wait_d = SW'(STALL_CLKS - 1);
    else if (wait_q != '0)  wait_d = wait_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

endmodule

// File: rtl/snoop_tracker.sv
module snoop_tracker
  import snp_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SNOOP_DLY  = 4,
  parameter int STALL_CLKS = 2,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            hit,
  input  logic            hitm,
  input  logic            rsp_done,
  output logic            q_full,
  output logic            req_err,
  output logic            snp_valid,
  output logic [IDXW-1:0] snp_tag,
  output logic [1:0]      snp_res,
  output logic            snp_snarf,
  output logic            snp_stall,
  output logic            rd_xfer,
  output logic            wr_xfer,
  output logic            mem_snarf
);

  logic rst_s1, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      rst_int_n <= rst_s1;
    end
  end

  logic            push, pop, resolve, stall, full, empty, pend_any;
  logic            due, head_ready, head_wr;
  logic [IDXW-1:0] wr_ptr, snp_ptr, rd_ptr;
  snp_res_e        res, head_res;

  assign push = req_valid && !full;
  assign pop  = rsp_done && head_ready;

  tq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_int_n), .push(push), .pop(pop), .resolve(resolve),
    .wr_ptr(wr_ptr), .snp_ptr(snp_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty), .pend_any(pend_any)
  );

  tq_entries #(.DEPTH(DEPTH), .SNOOP_DLY(SNOOP_DLY)) u_ents (
    .clk(clk), .rst_n(rst_int_n),
    .push(push), .push_idx(wr_ptr), .push_wr(req_write),
    .res_we(resolve), .res_idx(snp_ptr), .res_val(res),
    .pop(pop), .pop_idx(rd_ptr),
    .snp_due(due), .head_ready(head_ready), .head_wr(head_wr), .head_res(head_res)
  );

  snoop_ctl #(.STALL_CLKS(STALL_CLKS)) u_ctl (
    .clk(clk), .rst_n(rst_int_n), .pend_any(pend_any), .due(due),
    .hit(hit), .hitm(hitm), .resolve(resolve), .stall(stall), .res(res)
  );

  logic            vld_q, vld_d, snarf_q, snarf_d, stl_q, stl_d, err_q, err_d;
  logic [IDXW-1:0] tag_q, tag_d;
  snp_res_e        res_q, res_d;

  always_comb begin
    vld_d   = resolve;
    stl_d   = stall;
    err_d   = req_valid && full;
    tag_d   = tag_q;
    res_d   = res_q;
    snarf_d = 1'b0;
    if (resolve) begin
      tag_d   = snp_ptr;
      res_d   = res;
      snarf_d = (res == SNP_MOD);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q   <= 1'b0;
      stl_q   <= 1'b0;
      err_q   <= 1'b0;
      tag_q   <= '0;
      res_q   <= SNP_CLEAN;
      snarf_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      stl_q   <= stl_d;
      err_q   <= err_d;
      tag_q   <= tag_d;
      res_q   <= res_d;
      snarf_q <= snarf_d;
    end
  end

  assign q_full    = full;
  assign req_err   = err_q;
  assign snp_valid = vld_q;
  assign snp_tag   = tag_q;
  assign snp_res   = res_q;
  assign snp_snarf = snarf_q;
  assign snp_stall = stl_q;
  assign rd_xfer   = !empty && head_ready && !head_wr;
  assign wr_xfer   = !empty && head_ready && head_wr;
  assign mem_snarf = !empty && head_ready && (head_res == SNP_MOD);

endmodule

// File: rtl/snoop_tracker_chk.sv
module snoop_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       hit,
  input logic       hitm,
  input logic       q_full,
  input logic       req_err,
  input logic       snp_valid,
  input logic [1:0] snp_res,
  input logic       snp_stall,
  input logic       rd_xfer,
  input logic       wr_xfer,
  input logic       mem_snarf
);

  assert_xfer_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_xfer && wr_xfer));

  assert_err_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && q_full));

  assert_stall_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snp_stall |=> (!snp_valid && !snp_stall));

  assert_mod_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_res == 2'b10) |-> $past(hitm && !hit));

  assert_clean_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_res == 2'b00) |-> $past(!hit && !hitm));

  assert_snarf_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_snarf |-> (rd_xfer || wr_xfer));

endmodule

bind snoop_tracker snoop_tracker_chk i_chk (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .hit(hit), .hitm(hitm),
  .q_full(q_full), .req_err(req_err), .snp_valid(snp_valid), .snp_res(snp_res),
  .snp_stall(snp_stall), .rd_xfer(rd_xfer), .wr_xfer(wr_xfer), .mem_snarf(mem_snarf)
);

// File: tb/test_snoop_tracker.sv
`timescale 1ns/1ps
module test_snoop_tracker;

  logic clk = 1'b0;
  logic rst_n, req_valid, req_write, hit, hitm, rsp_done;
  logic q_full, req_err, snp_valid, snp_snarf, snp_stall, rd_xfer, wr_xfer, mem_snarf;
  logic [2:0] snp_tag;
  logic [1:0] snp_res;

  int checks = 0;
  int errors = 0;
  int exp_tag = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  snoop_tracker i_snoop_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .hit(hit), .hitm(hitm), .rsp_done(rsp_done), .q_full(q_full), .req_err(req_err),
    .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_res(snp_res), .snp_snarf(snp_snarf),
    .snp_stall(snp_stall), .rd_xfer(rd_xfer), .wr_xfer(wr_xfer), .mem_snarf(mem_snarf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R5: every result carries the next slot in acceptance order
  always @(posedge clk) begin
    #1;
    if (mon_en && snp_valid) begin
      chk(int'(snp_tag) == exp_tag, "R5", "snoop tag order", int'(snp_tag), exp_tag);
      exp_tag = (exp_tag + 1) % 8;
    end
  end

  task automatic do_reset();
    mon_en = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    hit = 1'b0; hitm = 1'b0; rsp_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!q_full && !req_err && !snp_valid && !snp_stall, "R1", "flags after reset",
        {q_full, req_err, snp_valid, snp_stall}, 0);
    chk(!rd_xfer && !wr_xfer && !mem_snarf, "R1", "data outputs after reset",
        {rd_xfer, wr_xfer, mem_snarf}, 0);
    exp_tag = 0;
    mon_en = 1'b1;
  endtask

  task automatic send(input bit wr);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_snoop(input string tag, input bit wr, input bit h, input bit hm,
                           input int nstall, input bit early_done, input int exp_res);
    int n = 0;
    int st = 0;
    bit got = 1'b0;
    hit  = (nstall > 0) ? 1'b1 : h;
    hitm = (nstall > 0) ? 1'b1 : hm;
    send(wr);
    if (early_done) rsp_done = 1'b1;
    while (!got && n < 40) begin
      @(posedge clk);
      #1;
      n++;
      rsp_done = 1'b0;
      if (snp_stall) begin
        st++;
        if (st == nstall) begin
          hit  = h;
          hitm = hm;
        end
      end
      if (snp_valid) got = 1'b1;
    end
    chk(got, tag, "result seen", int'(got), 1);
    chk(n == 4 + 2 * nstall, tag, "snoop latency", n, 4 + 2 * nstall);
    chk(st == nstall, "R4", "stall pulses", st, nstall);
    chk(int'(snp_res) == exp_res, "R3", "result code", int'(snp_res), exp_res);
    chk(snp_snarf == (exp_res == 2), "R3", "snarf with result", int'(snp_snarf),
        int'(exp_res == 2));
    chk(rd_xfer == !wr && wr_xfer == wr, "R8", "head direction",
        {rd_xfer, wr_xfer}, {!wr, wr});
    chk(mem_snarf == (exp_res == 2), "R9", "memory capture flag", int'(mem_snarf),
        int'(exp_res == 2));
    if (early_done)
      chk(rd_xfer || wr_xfer, "R7", "early response ignored", int'(rd_xfer || wr_xfer), 1);
    @(negedge clk) rsp_done = 1'b1;
    @(negedge clk) rsp_done = 1'b0;
    chk(!rd_xfer && !wr_xfer && !mem_snarf, "R7", "retired on response",
        {rd_xfer, wr_xfer, mem_snarf}, 0);
    hit = 1'b0;
    hitm = 1'b0;
  endtask

  task automatic fill_and_drain();
    for (int k = 0; k < 8; k++) begin
      send(k[0]);
      chk(q_full == (k == 7), "R6", "full flag while filling", int'(q_full), int'(k == 7));
    end
    send(1'b0);
    chk(req_err == 1'b1, "R6", "error pulse on refused request", int'(req_err), 1);
    @(negedge clk);
    chk(req_err == 1'b0, "R6", "error pulse one cycle", int'(req_err), 0);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(rd_xfer == !k[0] && wr_xfer == k[0], "R8", "head direction in order",
          {rd_xfer, wr_xfer}, {!k[0], k[0]});
      rsp_done = 1'b1;
    end
    @(negedge clk) rsp_done = 1'b0;
    chk(!rd_xfer && !wr_xfer && !q_full, "R6", "refused request never stored",
        {rd_xfer, wr_xfer, q_full}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    run_snoop("R2", 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
    run_snoop("R2", 1'b1, 1'b1, 1'b0, 0, 1'b0, 1);
    run_snoop("R2", 1'b0, 1'b0, 1'b1, 0, 1'b0, 2);
    run_snoop("R4", 1'b1, 1'b0, 1'b1, 1, 1'b0, 2);
    run_snoop("R4", 1'b0, 1'b1, 1'b0, 2, 1'b0, 1);
    run_snoop("R7", 1'b0, 1'b0, 1'b0, 0, 1'b1, 0);
    fill_and_drain();
    run_snoop("R5", 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);
    do_reset();
    run_snoop("R1", 1'b0, 1'b1, 1'b0, 0, 1'b0, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule